// File: doc/BRIEF.md
# Streaming Vector Execution Engine (memory operands, descriptor addressed)

This unit runs one integer vector instruction whose operands and result live in memory rather than in a register file. Each instruction names two source vectors and one destination vector. Each vector is a single 64-bit descriptor that packs an element count and a base word address. The engine fetches both source streams word by word from consecutive addresses. It pairs the elements, passes them through a fixed-latency arithmetic pipeline, and stores each result at the matching consecutive destination address. When predication is enabled, a packed bit vector in memory, named by a fourth descriptor, decides which destination words are written. The other destination words keep their old contents.

Each source stream has a private input buffer. Results drain through an output buffer to a single write port. Every memory port uses a valid/ready request handshake, so a memory that stalls on any port at any time delays the engine without losing data. Predication is resolved inside the pipeline and adds no cycles to the element stream. The linked multiply-add form combines a multiply by a scalar and an add in one instruction, which gives two arithmetic operations per element.

A controller places the four descriptors, the opcode, the mask enable and the scalar on the inputs, pulses `start`, and waits for the one-cycle `done` pulse.

Top module: `vec_m2m_engine`

## Requirements
- R1: A descriptor carries the element count in bits 63:48 and the base word address in bits 47:0. Element i of a stream is at base + i. The element count of the instruction comes from the destination descriptor, and each source port issues exactly that many read requests.
- R2: The opcode selects the result: 0 gives a+b, 1 gives a-b, 2 gives a*b, and 3 gives the linked triad a*s+b, where s is `triad_scalar` captured at start. All results wrap modulo 2^64.
- R3: A destination count of zero raises `done` within three cycles of `start` and issues no read or write requests.
- R4: With `mask_en` set, element i is written only if bit (i mod 64) of the mask word at mask base + i/64 is 1. Other destination words are left unchanged, and the mask port reads ceil(count/64) words.
- R5: Results stay correct under any pattern of deasserted ready on any port. No element is dropped or written twice.
- R6: The requests a source port has accepted but the engine has not yet consumed never exceed the input buffer depth of 8.
- R7: `done` is a one-cycle pulse raised only after the last write has been accepted. `busy` stays high from start until that pulse.
- R8: A `start` pulse while `busy` is high is ignored, and the running instruction completes unchanged.
- R9: After reset, and whenever the engine is idle, `busy`, `done` and every request valid are low.
- R10: Once `w_valid` is raised, it stays high with stable address and data until `w_ready` accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an instruction when idle |
| op | input | 2 | Operation code (R2) |
| mask_en | input | 1 | Enable bit-vector predication |
| desc_src_a | input | 64 | First source descriptor |
| desc_src_b | input | 64 | Second source descriptor |
| desc_dst | input | 64 | Destination descriptor, sets the element count |
| desc_mask | input | 64 | Mask descriptor (base address used) |
| triad_scalar | input | 64 | Scalar multiplier for the triad |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| a_req_valid | output | 1 | Source A read request valid |
| a_req_addr | output | 48 | Source A read address |
| a_req_ready | input | 1 | Source A request accepted |
| a_rsp_valid | input | 1 | Source A read data valid |
| a_rsp_data | input | 64 | Source A read data |
| b_req_valid | output | 1 | Source B read request valid |
| b_req_addr | output | 48 | Source B read address |
| b_req_ready | input | 1 | Source B request accepted |
| b_rsp_valid | input | 1 | Source B read data valid |
| b_rsp_data | input | 64 | Source B read data |
| m_req_valid | output | 1 | Mask read request valid |
| m_req_addr | output | 48 | Mask read address |
| m_req_ready | input | 1 | Mask request accepted |
| m_rsp_valid | input | 1 | Mask read data valid |
| m_rsp_data | input | 64 | Mask read data |
| w_valid | output | 1 | Write request valid |
| w_addr | output | 48 | Write address |
| w_data | output | 64 | Write data |
| w_ready | input | 1 | Write accepted |

## Verification
The bench uses vector lengths of one, exactly one mask word, and just past one and two mask words. A design that mishandles the mask-word boundary either skips a word fetch or applies stale bits, so the wrong destination words change. Some runs throttle every ready with a pseudo-random pattern. A design that lets the output buffer overrun or re-issues an element would then write garbage or write a word twice, and the write count would disagree with the count of set mask bits. Directed cases issue a zero-length instruction and a restart while busy. A design that mishandles these would touch memory or silently switch operation in mid-stream.

// File: rtl/vme_pkg.sv
package vme_pkg;
   localparam int DESC_W = 64;

   typedef enum logic [1:0] {
      OP_ADD   = 2'd0,
      OP_SUB   = 2'd1,
      OP_MUL   = 2'd2,
      OP_TRIAD = 2'd3
   } vme_op_e;
endpackage

// File: rtl/vme_fifo.sv
module vme_fifo #(
   parameter int W     = 64,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
      $error("vme_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0] store [DEPTH];
   logic [PW:0]  wp, rp;

   assign empty = (wp == rp);
   assign full  = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
   assign dout  = store[rp[PW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push && !full) wp <= wp + 1'b1;
         if (pop && !empty) rp <= rp + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full) store[wp[PW-1:0]] <= din;
   end
endmodule

// File: rtl/vme_stream_rd.sv
module vme_stream_rd #(
   parameter int DW    = 64,
   parameter int AW    = 48,
   parameter int CW    = 17,
   parameter int DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic [CW-1:0] count,
   output logic          req_valid,
   output logic [AW-1:0] req_addr,
   input  logic          req_ready,
   input  logic          rsp_valid,
   input  logic [DW-1:0] rsp_data,
   input  logic          pop,
   output logic [DW-1:0] data,
   output logic          avail
);
   localparam int HW = $clog2(DEPTH + 1);

   logic [AW-1:0] addr_q;
   logic [CW-1:0] remain_q;
   logic [HW-1:0] held_q;
   logic          hs, empty, full;

   assign req_valid = (remain_q != '0) && (held_q < HW'(DEPTH));
   assign req_addr  = addr_q;
   assign hs        = req_valid && req_ready;
   assign avail     = !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         remain_q <= '0;
         held_q   <= '0;
      end else begin
         if (load) begin
            addr_q   <= base;
            remain_q <= count;
         end else if (hs) begin
            addr_q   <= addr_q + 1'b1;
            remain_q <= remain_q - 1'b1;
         end
         held_q <= held_q + HW'(hs) - HW'(pop);
      end
   end

   vme_fifo #(.W(DW), .DEPTH(DEPTH)) buf_i (
      .clk  (clk),
      .rst_n(rst_n),
      .push (rsp_valid),
      .din  (rsp_data),
      .pop  (pop),
      .dout (data),
      .empty(empty),
      .full (full)
   );
endmodule

// File: rtl/vme_alu_pipe.sv
module vme_alu_pipe
   import vme_pkg::*;
#(
   parameter int DW  = 64,
   parameter int TW  = 49,
   parameter int LAT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          in_valid,
   input  vme_op_e       op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic [DW-1:0] s,
   input  logic [TW-1:0] in_tag,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output logic [TW-1:0] out_tag,
   output logic          occupied
);
   if (LAT < 2) begin : g_bad_lat
      $error("vme_alu_pipe: LAT must be at least 2");
   end

   // stage 1: multiply, stage 2: combine, stages 3..LAT: alignment
   logic          v1;
   vme_op_e       op1;
   logic [DW-1:0] a1, b1, p1;
   logic [TW-1:0] t1;
   logic [DW-1:0] res;

   logic [LAT-1:1] sv;
   logic [DW-1:0]  sd [LAT-1:1];
   logic [TW-1:0]  st [LAT-1:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v1 <= 1'b0;
      else if (adv) v1 <= in_valid;
   end

   always_ff @(posedge clk) begin
      if (adv) begin
         op1 <= op;
         a1  <= a;
         b1  <= b;
         p1  <= a * ((op == OP_MUL) ? b : s);
         t1  <= in_tag;
      end
   end

   always_comb begin
      unique case (op1)
         OP_ADD:  res = a1 + b1;
         OP_SUB:  res = a1 - b1;
         OP_MUL:  res = p1;
         default: res = p1 + b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sv[1] <= 1'b0;
      else if (adv) sv[1] <= v1;
   end

   always_ff @(posedge clk) begin
      if (adv) begin
         sd[1] <= res;
         st[1] <= t1;
      end
   end

   for (genvar k = 2; k < LAT; k++) begin : g_align
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sv[k] <= 1'b0;
         else if (adv) sv[k] <= sv[k-1];
      end
      always_ff @(posedge clk) begin
         if (adv) begin
            sd[k] <= sd[k-1];
            st[k] <= st[k-1];
         end
      end
   end

   assign out_valid = sv[LAT-1];
   assign out_data  = sd[LAT-1];
   assign out_tag   = st[LAT-1];
   assign occupied  = v1 || (|sv);
endmodule

// File: rtl/vec_m2m_engine.sv
module vec_m2m_engine
   import vme_pkg::*;
#(
   parameter int DW          = 64,
   parameter int AW          = 48,
   parameter int LW          = 16,
   parameter int IBUF_DEPTH  = 8,
   parameter int OBUF_DEPTH  = 4,
   parameter int MBUF_DEPTH  = 2,
   parameter int LAT         = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    op,
   input  logic          mask_en,
   input  logic [63:0]   desc_src_a,
   input  logic [63:0]   desc_src_b,
   input  logic [63:0]   desc_dst,
   input  logic [63:0]   desc_mask,
   input  logic [DW-1:0] triad_scalar,
   output logic          busy,
   output logic          done,
   output logic          a_req_valid,
   output logic [AW-1:0] a_req_addr,
   input  logic          a_req_ready,
   input  logic          a_rsp_valid,
   input  logic [DW-1:0] a_rsp_data,
   output logic          b_req_valid,
   output logic [AW-1:0] b_req_addr,
   input  logic          b_req_ready,
   input  logic          b_rsp_valid,
   input  logic [DW-1:0] b_rsp_data,
   output logic          m_req_valid,
   output logic [AW-1:0] m_req_addr,
   input  logic          m_req_ready,
   input  logic          m_rsp_valid,
   input  logic [DW-1:0] m_rsp_data,
   output logic          w_valid,
   output logic [AW-1:0] w_addr,
   output logic [DW-1:0] w_data,
   input  logic          w_ready
);
   localparam int CW  = LW + 1;
   localparam int MIX = $clog2(DW);
   localparam int TW  = AW + 1;

   if (LW + AW != DESC_W) begin : g_bad_desc
      $error("vec_m2m_engine: LW + AW must fill one descriptor word");
   end
   if ((1 << MIX) != DW) begin : g_bad_dw
      $error("vec_m2m_engine: DW must be a power of two");
   end

   logic          busy_q, done_q, men_q;
   vme_op_e       op_q;
   logic [DW-1:0] s_q;
   logic [CW-1:0] len_q, idx_q;
   logic [AW-1:0] dbase_q;

   logic          load, issue, adv, finish;
   logic [CW-1:0] len_in, mcount;
   logic          a_pop, b_pop, m_pop;
   logic          a_avail, b_avail, m_avail;
   logic [DW-1:0] a_data, b_data, m_data;
   logic          keep;
   logic          pv, occ;
   logic [DW-1:0] pd;
   logic [TW-1:0] pt;
   logic          o_empty, o_full, o_push;
   logic [AW+DW-1:0] o_dout;

   assign load   = start && !busy_q;
   assign len_in = CW'(desc_dst[DESC_W-1 -: LW]);
   assign mcount = mask_en ? CW'((32'(len_in) + DW - 1) >> MIX) : '0;

   assign adv    = !(pv && pt[AW] && o_full);
   assign issue  = busy_q && adv && (idx_q != len_q) && a_avail && b_avail
                   && (!men_q || m_avail);
   assign a_pop  = issue;
   assign b_pop  = issue;
   assign m_pop  = issue && men_q
                   && ((idx_q[MIX-1:0] == '1) || (idx_q == len_q - 1'b1));
   assign keep   = !men_q || m_data[idx_q[MIX-1:0]];
   assign o_push = pv && pt[AW] && adv;
   assign finish = busy_q && (idx_q == len_q) && !occ && o_empty;

   vme_stream_rd #(.DW(DW), .AW(AW), .CW(CW), .DEPTH(IBUF_DEPTH)) rd_a_i (
      .clk(clk), .rst_n(rst_n), .load(load), .base(desc_src_a[AW-1:0]),
      .count(len_in), .req_valid(a_req_valid), .req_addr(a_req_addr),
      .req_ready(a_req_ready), .rsp_valid(a_rsp_valid), .rsp_data(a_rsp_data),
      .pop(a_pop), .data(a_data), .avail(a_avail)
   );

   vme_stream_rd #(.DW(DW), .AW(AW), .CW(CW), .DEPTH(IBUF_DEPTH)) rd_b_i (
      .clk(clk), .rst_n(rst_n), .load(load), .base(desc_src_b[AW-1:0]),
      .count(len_in), .req_valid(b_req_valid), .req_addr(b_req_addr),
      .req_ready(b_req_ready), .rsp_valid(b_rsp_valid), .rsp_data(b_rsp_data),
      .pop(b_pop), .data(b_data), .avail(b_avail)
   );

   vme_stream_rd #(.DW(DW), .AW(AW), .CW(CW), .DEPTH(MBUF_DEPTH)) rd_m_i (
      .clk(clk), .rst_n(rst_n), .load(load), .base(desc_mask[AW-1:0]),
      .count(mcount), .req_valid(m_req_valid), .req_addr(m_req_addr),
      .req_ready(m_req_ready), .rsp_valid(m_rsp_valid), .rsp_data(m_rsp_data),
      .pop(m_pop), .data(m_data), .avail(m_avail)
   );

   vme_alu_pipe #(.DW(DW), .TW(TW), .LAT(LAT)) alu_i (
      .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(issue), .op(op_q),
      .a(a_data), .b(b_data), .s(s_q),
      .in_tag({keep, dbase_q + AW'(idx_q)}),
      .out_valid(pv), .out_data(pd), .out_tag(pt), .occupied(occ)
   );

   vme_fifo #(.W(AW + DW), .DEPTH(OBUF_DEPTH)) obuf_i (
      .clk(clk), .rst_n(rst_n), .push(o_push), .din({pt[AW-1:0], pd}),
      .pop(w_valid && w_ready), .dout(o_dout), .empty(o_empty), .full(o_full)
   );

   assign w_valid = !o_empty;
   assign w_addr  = o_dout[AW+DW-1:DW];
   assign w_data  = o_dout[DW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         men_q   <= 1'b0;
         op_q    <= OP_ADD;
         s_q     <= '0;
         len_q   <= '0;
         idx_q   <= '0;
         dbase_q <= '0;
      end else begin
         done_q <= finish;
         if (load) begin
            busy_q  <= 1'b1;
            men_q   <= mask_en;
            op_q    <= vme_op_e'(op);
            s_q     <= triad_scalar;
            len_q   <= len_in;
            idx_q   <= '0;
            dbase_q <= desc_dst[AW-1:0];
         end else begin
            if (issue)  idx_q  <= idx_q + 1'b1;
            if (finish) busy_q <= 1'b0;
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
endmodule

// File: rtl/vme_checker.sv
module vme_checker #(
   parameter int DEPTH = 8,
   parameter int AW    = 48,
   parameter int DW    = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          a_req_valid,
   input logic          a_req_ready,
   input logic          a_pop,
   input logic          b_req_valid,
   input logic          b_req_ready,
   input logic          b_pop,
   input logic          m_req_valid,
   input logic          w_valid,
   input logic          w_ready,
   input logic [AW-1:0] w_addr,
   input logic [DW-1:0] w_data
);
   localparam int CNTW = $clog2(DEPTH + 1) + 2;

   logic [CNTW-1:0] out_a, out_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_a <= '0;
         out_b <= '0;
      end else begin
         out_a <= out_a + CNTW'(a_req_valid && a_req_ready) - CNTW'(a_pop);
         out_b <= out_b + CNTW'(b_req_valid && b_req_ready) - CNTW'(b_pop);
      end
   end

   a_r6_no_overflow_a: assert property (@(posedge clk) disable iff (!rst_n)
      out_a <= CNTW'(DEPTH));
   a_r6_no_overflow_b: assert property (@(posedge clk) disable iff (!rst_n)
      out_b <= CNTW'(DEPTH));
   a_r10_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
      w_valid && !w_ready |=> w_valid && $stable(w_addr) && $stable(w_data));
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !a_req_valid && !b_req_valid && !m_req_valid && !w_valid);
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r7_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   a_r7_no_write_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !w_valid);
endmodule

bind vec_m2m_engine vme_checker #(.DEPTH(IBUF_DEPTH), .AW(AW), .DW(DW)) chk_i (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
   .a_req_valid(a_req_valid), .a_req_ready(a_req_ready), .a_pop(a_pop),
   .b_req_valid(b_req_valid), .b_req_ready(b_req_ready), .b_pop(b_pop),
   .m_req_valid(m_req_valid), .w_valid(w_valid), .w_ready(w_ready),
   .w_addr(w_addr), .w_data(w_data)
);

// File: tb/vec_m2m_engine_tb.sv
module vec_m2m_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [47:0] BASE_A = 48'h000;
   localparam logic [47:0] BASE_B = 48'h100;
   localparam logic [47:0] BASE_D = 48'h200;
   localparam logic [47:0] BASE_M = 48'h300;

   typedef struct packed {
      logic [1:0]  op;
      logic [15:0] len;
      logic        men;
      logic        stall;
      logic [7:0]  seed;
      logic [63:0] s;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 16'd5,   1'b0, 1'b0, 8'h11, 64'd0},
      '{2'd1, 16'd17,  1'b0, 1'b1, 8'h22, 64'd0},
      '{2'd2, 16'd9,   1'b1, 1'b0, 8'h33, 64'd0},
      '{2'd3, 16'd33,  1'b1, 1'b1, 8'h44, 64'hFFFF_FFFF_FFFF_FFFD},
      '{2'd0, 16'd70,  1'b1, 1'b1, 8'h55, 64'd0},
      '{2'd3, 16'd1,   1'b0, 1'b0, 8'h66, 64'h0123_4567_89AB_CDEF},
      '{2'd1, 16'd64,  1'b1, 1'b0, 8'h77, 64'd0},
      '{2'd2, 16'd130, 1'b0, 1'b1, 8'h88, 64'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'd0;
   logic        mask_en = 1'b0;
   logic [63:0] desc_src_a = '0, desc_src_b = '0, desc_dst = '0, desc_mask = '0;
   logic [63:0] triad_scalar = '0;
   logic        busy, done;
   logic        a_req_valid, b_req_valid, m_req_valid, w_valid;
   logic [47:0] a_req_addr, b_req_addr, m_req_addr, w_addr;
   logic [63:0] w_data;
   logic        a_req_ready, b_req_ready, m_req_ready, w_ready;
   logic        a_rsp_valid = 1'b0, b_rsp_valid = 1'b0, m_rsp_valid = 1'b0;
   logic [63:0] a_rsp_data = '0, b_rsp_data = '0, m_rsp_data = '0;

   logic [63:0] mem [1024];
   logic [63:0] expd [256];
   logic [15:0] lfsr = 16'hACE1;
   logic        stall_mode = 1'b0;
   int          n_checks = 0, n_fail = 0;
   int          wr_cnt = 0, rda_cnt = 0, rdb_cnt = 0, rdm_cnt = 0, done_cnt = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vec_m2m_engine dut_i (.*);

   assign a_req_ready = stall_mode ? lfsr[0] : 1'b1;
   assign b_req_ready = stall_mode ? lfsr[3] : 1'b1;
   assign m_req_ready = stall_mode ? lfsr[6] : 1'b1;
   assign w_ready     = stall_mode ? (lfsr[9] | lfsr[12]) : 1'b1;

   // memory model: one-cycle read latency, in order
   always @(posedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a_rsp_valid <= a_req_valid && a_req_ready;
      a_rsp_data  <= mem[a_req_addr[9:0]];
      b_rsp_valid <= b_req_valid && b_req_ready;
      b_rsp_data  <= mem[b_req_addr[9:0]];
      m_rsp_valid <= m_req_valid && m_req_ready;
      m_rsp_data  <= mem[m_req_addr[9:0]];
      if (a_req_valid && a_req_ready) rda_cnt <= rda_cnt + 1;
      if (b_req_valid && b_req_ready) rdb_cnt <= rdb_cnt + 1;
      if (m_req_valid && m_req_ready) rdm_cnt <= rdm_cnt + 1;
      if (w_valid && w_ready) begin
         mem[w_addr[9:0]] <= w_data;
         wr_cnt <= wr_cnt + 1;
      end
      if (done) done_cnt <= done_cnt + 1;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] mix(input int i, input logic [7:0] seed, input int k);
      return (64'h9E37_79B9_7F4A_7C15 * 64'(i + 1 + k * 977)) ^ {8{seed}};
   endfunction

   task automatic fill(input logic [7:0] seed);
      for (int i = 0; i < 256; i++) begin
         mem[BASE_A + 48'(i)] = mix(i, seed, 1);
         mem[BASE_B + 48'(i)] = mix(i, seed, 2);
         mem[BASE_D + 48'(i)] = 64'hDEAD_0000_0000_0000 | 64'(i);
         mem[BASE_M + 48'(i)] = mix(i, seed, 3);
      end
   endtask

   function automatic logic [63:0] desc(input logic [15:0] len, input logic [47:0] base);
      return {len, base};
   endfunction

   task automatic pulse_start(input logic [1:0] o, input logic [15:0] len,
                              input logic men, input logic [63:0] s,
                              input logic [47:0] dbase);
      @(negedge clk);
      op = o; mask_en = men; triad_scalar = s;
      desc_src_a = desc(16'd0, BASE_A);
      desc_src_b = desc(16'd0, BASE_B);
      desc_dst   = desc(len, dbase);
      desc_mask  = desc(16'd0, BASE_M);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output bit ok);
      ok = 1'b0;
      for (int c = 0; c < 20000; c++) begin
         if (done) begin ok = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic run_vec(input vec_t v);
      int kept = 0;
      int wr0, ra0, rb0, rm0;
      bit ok, all_ok;
      int bad_i;
      logic [63:0] av, bv;
      fill(v.seed);
      stall_mode = v.stall;
      for (int i = 0; i < 256; i++) begin
         av = mem[BASE_A + 48'(i)];
         bv = mem[BASE_B + 48'(i)];
         expd[i] = mem[BASE_D + 48'(i)];
         if (i < int'(v.len) &&
             (!v.men || mem[BASE_M + 48'(i / 64)][i % 64])) begin
            kept++;
            case (v.op)
               2'd0: expd[i] = av + bv;
               2'd1: expd[i] = av - bv;
               2'd2: expd[i] = av * bv;
               default: expd[i] = av * v.s + bv;
            endcase
         end
      end
      wr0 = wr_cnt; ra0 = rda_cnt; rb0 = rdb_cnt; rm0 = rdm_cnt;
      pulse_start(v.op, v.len, v.men, v.s, BASE_D);
      wait_done(ok);
      check(ok, "R7", "done seen", 64'(ok), 64'd1);
      // R7: every kept write already accepted when done is high
      check(wr_cnt - wr0 == kept, "R7", "writes before done", 64'(wr_cnt - wr0), 64'(kept));
      // R1: each source reads exactly the destination count
      check(rda_cnt - ra0 == int'(v.len) && rdb_cnt - rb0 == int'(v.len), "R1",
            "source reads", 64'(rda_cnt - ra0), 64'(v.len));
      // R4: mask words read
      check(rdm_cnt - rm0 == (v.men ? (int'(v.len) + 63) / 64 : 0), "R4", "mask reads",
            64'(rdm_cnt - rm0), 64'(v.men ? (int'(v.len) + 63) / 64 : 0));
      // R2 R4 R5: full destination image, including untouched neighbours
      all_ok = 1'b1; bad_i = 0;
      for (int i = 0; i < 256; i++) begin
         if (all_ok && mem[BASE_D + 48'(i)] !== expd[i]) begin
            all_ok = 1'b0; bad_i = i;
         end
      end
      check(all_ok, v.men ? "R4" : (v.stall ? "R5" : "R2"), $sformatf("dest word %0d", bad_i),
            mem[BASE_D + 48'(bad_i)], expd[bad_i]);
      stall_mode = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      bit ok;
      int wr0, ra0, dc0;
      vec_t rv;
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R9: reset state
      check(!busy && !done && !a_req_valid && !b_req_valid && !m_req_valid && !w_valid,
            "R9", "reset outputs", {busy, done, a_req_valid, w_valid}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!busy && !done, "R9", "idle after reset", {busy, done}, 64'd0);

      for (int n = 0; n < NV; n++) run_vec(VECS[n]);

      // R3: zero length
      fill(8'h99);
      wr0 = wr_cnt; ra0 = rda_cnt + rdb_cnt + rdm_cnt;
      pulse_start(2'd0, 16'd0, 1'b1, 64'd0, BASE_D);
      ok = 1'b0;
      for (int c = 0; c < 2; c++) begin
         if (done) ok = 1'b1;
         @(negedge clk);
      end
      check(ok, "R3", "zero-length done", 64'(ok), 64'd1);
      check(wr_cnt == wr0 && rda_cnt + rdb_cnt + rdm_cnt == ra0, "R3",
            "zero-length traffic", 64'(wr_cnt - wr0), 64'd0);

      // R8: restart while busy is ignored
      rv = '{2'd0, 16'd40, 1'b0, 1'b1, 8'hA5, 64'd0};
      fill(rv.seed);
      for (int i = 0; i < 40; i++)
         expd[i] = mem[BASE_A + 48'(i)] + mem[BASE_B + 48'(i)];
      stall_mode = 1'b1;
      dc0 = done_cnt;
      pulse_start(2'd0, 16'd40, 1'b0, 64'd0, BASE_D);
      repeat (3) @(negedge clk);
      check(busy, "R7", "busy mid-run", 64'(busy), 64'd1);
      pulse_start(2'd2, 16'd7, 1'b0, 64'd0, BASE_M);
      wait_done(ok);
      repeat (60) @(negedge clk);
      stall_mode = 1'b0;
      check(done_cnt - dc0 == 1, "R8", "done pulses", 64'(done_cnt - dc0), 64'd1);
      ok = 1'b1;
      for (int i = 0; i < 40; i++) if (mem[BASE_D + 48'(i)] !== expd[i]) ok = 1'b0;
      check(ok, "R8", "first instruction result", 64'(ok), 64'd1);
      check(mem[BASE_M] === mix(0, rv.seed, 3), "R8", "second dest untouched",
            mem[BASE_M], mix(0, rv.seed, 3));
      check(!busy && !a_req_valid && !w_valid, "R9", "idle after run",
            {busy, a_req_valid, w_valid}, 64'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int c = 0; c < 190000; c++) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL R7 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule